// File: doc/BRIEF.md
# Capture, compare and pulse-width channel

One timer-driven channel with three families of behaviour chosen by a 4-bit mode field. In capture modes it copies a free-running 16-bit timer into its 16-bit value register on selected edges of an input pin, optionally counting 4 or 16 rising edges per capture. In compare modes it watches that timer for equality with the value register and then sets or clears its output, raises only its event flag, or pulses a trigger line meant to start a converter. In pulse-width modes it takes the count and period-match pulse of an external 8-bit period timer, extended by a 2-bit sub-count, and produces a double-buffered 10-bit duty waveform.

The timers live outside the channel. Software reaches the channel through a one-cycle write port with four addresses. Capture results are read on `ccpr_o`.

Top module: `ccp_channel`

## Requirements
- R1: After reset `out_o`, `out_en_o`, `irq_o` and `trig_o` are 0, and `ccpr_o` is 0.
- R2: Write addresses: 0 is control (data bits 3:0 are the mode, bits 5:4 are the duty low bits), 1 is the low byte of the value register, 2 is its high byte, and 3 is the flag. With mode 0 to 3 the channel is idle. `out_en_o`, `out_o` and `trig_o` stay 0, pin edges and timer equality set no flag, and `ccpr_o` changes only by writes.
- R3: Mode 4 captures on each falling pin edge and mode 5 on each rising edge. A capture loads `timer_i` into `ccpr_o` and sets the flag. It happens at the second rising clock edge after the pin changes, because the pin passes a two-stage synchroniser.
- R4: Mode 6 captures on every 4th rising edge and mode 7 on every 16th, counted from the moment the mode was entered.
- R5: A control write that changes the mode clears the edge prescale count.
- R6: The flag (`irq_o`) is sticky. It is set by any capture or compare event. It is cleared by writing address 3 with bit 0 = 0, and writing bit 0 = 1 has no effect. An event in the same cycle as a clear leaves it set.
- R7: Entering mode 8 drives `out_o` low and entering mode 9 drives it high. `out_en_o` is 1 in both modes. On a match, mode 8 drives `out_o` high and mode 9 drives it low, at the edge where `timer_i` equals `ccpr_o`.
- R8: On a match, mode 10 sets only the flag and mode 11 sets the flag and pulses `trig_o` for exactly one cycle. `out_en_o` is 0 in both modes.
- R9: A compare event fires once for each entry into equality. Holding the timer at the match value gives no further events.
- R10: Modes 12 to 15 drive the duty waveform with `out_en_o` = 1. D = {value high byte, control bits 5:4}, and the count C = {`pwm_tmr_i`, `pwm_sub_i`}. `out_o` goes high at the edge that samples `period_i`, unless D is 0. It goes low at the edge that samples C + 1 = D. With a count advancing once per clock, each period is therefore high for min(D, period length) cycles.
- R11: D is double-buffered. A new duty is used only from the first period match after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 low byte, 2 high byte, 3 flag |
| wr_data_i | input | 8 | Write data |
| timer_i | input | 16 | Free-running capture/compare timer |
| pwm_tmr_i | input | 8 | Period timer count |
| pwm_sub_i | input | 2 | Period timer sub-count (low bits of the extended count) |
| period_i | input | 1 | Period-match pulse from the period timer |
| pin_i | input | 1 | Capture input pin |
| out_o | output | 1 | Channel output level |
| out_en_o | output | 1 | Output drive enable |
| irq_o | output | 1 | Sticky event flag |
| trig_o | output | 1 | One-cycle special-event trigger |
| ccpr_o | output | 16 | Capture/compare value register |

## Verification
The hardest situation to reach is a stale partial prescale count surviving a mode switch. Only a run of rising edges that does not complete a capture reveals it. The stimulus gives three edges in the divide-by-4 mode, switches to the divide-by-16 mode and checks that exactly the sixteenth later edge captures. It sets up a clear racing a compare event in the same way, by placing the timer on the match value in the very cycle the clear is written. Duty buffering is exercised by rewriting the duty in the middle of a measured period.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int unsigned SUB_W = 2;  // duty low bits held in the control register

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LO   = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_FLAG = 2'd3
  } ccp_addr_e;

  function automatic logic is_off(input logic [3:0] m);
    return m[3:2] == 2'b00;
  endfunction
  function automatic logic is_cap(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction
  function automatic logic is_cmp(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction
  function automatic logic is_pwm(input logic [3:0] m);
    return m[3:2] == 2'b11;
  endfunction
endpackage

// File: rtl/ccp_edge_capture.sv
module ccp_edge_capture #(
  parameter int unsigned PRE_A = 4,
  parameter int unsigned PRE_B = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  input  logic       clr_i,
  input  logic       pin_i,
  output logic       fire_o
);
  localparam int unsigned CNT_W = $clog2(PRE_B);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign rise = s1_q & ~s2_q;
  assign fall = ~s1_q & s2_q;

  always_comb begin
    unique case (sel_i)
      2'd0:    hit = fall;
      2'd1:    hit = rise;
      2'd2:    hit = rise && (cnt_q == CNT_W'(PRE_A - 1));
      default: hit = rise && (cnt_q == CNT_W'(PRE_B - 1));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || !en_i)         cnt_q <= '0;
    else if (rise && sel_i[1])       cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  assign fire_o = en_i & hit;
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] ref_i,
  output logic          fire_o
);
  logic eq, eq_q;

  assign eq = (timer_i == ref_i);

  // track equality in every mode so entering compare never sees a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  assign fire_o = en_i & eq & ~eq_q;
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int unsigned PW  = 8,
  parameter int unsigned SW  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             period_i,
  input  logic [PW-1:0]    tmr_i,
  input  logic [SW-1:0]    sub_i,
  input  logic [PW+SW-1:0] duty_buf_i,
  output logic             lvl_o
);
  localparam int unsigned CW = PW + SW;

  logic [CW-1:0] duty_q;
  logic [CW:0]   cnt_nx;
  logic          lvl_q;

  assign cnt_nx = {1'b0, tmr_i, sub_i} + (CW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      lvl_q  <= 1'b0;
    end else if (!en_i) begin
      lvl_q  <= 1'b0;
    end else if (period_i) begin
      duty_q <= duty_buf_i;
      lvl_q  <= (duty_buf_i != '0);
    end else if (cnt_nx == {1'b0, duty_q}) begin
      lvl_q  <= 1'b0;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned PRE_A = 4,
  parameter int unsigned PRE_B = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [2*DW-1:0] timer_i,
  input  logic [DW-1:0]   pwm_tmr_i,
  input  logic [SUB_W-1:0] pwm_sub_i,
  input  logic            period_i,
  input  logic            pin_i,
  output logic            out_o,
  output logic            out_en_o,
  output logic            irq_o,
  output logic            trig_o,
  output logic [2*DW-1:0] ccpr_o
);
  localparam int unsigned TW = 2 * DW;

  logic [3:0]       mode_q;
  logic [SUB_W-1:0] dlo_q;
  logic [TW-1:0]    ccpr_q;
  logic             flag_q, out_q, trig_q;
  logic             wr_ctrl, mode_chg, cap_fire, cmp_fire, pwm_lvl;
  logic [3:0]       mode_nx;

  assign wr_ctrl  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign mode_nx  = wr_data_i[3:0];
  assign mode_chg = wr_ctrl && (mode_nx != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dlo_q  <= '0;
    end else if (wr_ctrl) begin
      mode_q <= mode_nx;
      dlo_q  <= wr_data_i[4 +: SUB_W];
    end
  end

  ccp_edge_capture #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (is_cap(mode_q)),
    .sel_i  (mode_q[1:0]),
    .clr_i  (mode_chg),
    .pin_i  (pin_i),
    .fire_o (cap_fire)
  );

  ccp_compare #(.TW(TW)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (is_cmp(mode_q)),
    .timer_i (timer_i),
    .ref_i   (ccpr_q),
    .fire_o  (cmp_fire)
  );

  ccp_pwm #(.PW(DW), .SW(SUB_W)) u_pwm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (is_pwm(mode_q)),
    .period_i   (period_i),
    .tmr_i      (pwm_tmr_i),
    .sub_i      (pwm_sub_i),
    .duty_buf_i ({ccpr_q[TW-1:DW], dlo_q}),
    .lvl_o      (pwm_lvl)
  );

  // capture beats a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         ccpr_q <= '0;
    else if (cap_fire)                                   ccpr_q <= timer_i;
    else if (wr_en_i && wr_addr_i == ADDR_LO)            ccpr_q[DW-1:0]  <= wr_data_i;
    else if (wr_en_i && wr_addr_i == ADDR_HI)            ccpr_q[TW-1:DW] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                              flag_q <= 1'b0;
    else if (cap_fire || cmp_fire)                            flag_q <= 1'b1;
    else if (wr_en_i && wr_addr_i == ADDR_FLAG && !wr_data_i[0]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= cmp_fire && (mode_q == 4'd11);
      if (mode_chg && mode_nx == 4'd8)      out_q <= 1'b0;
      else if (mode_chg && mode_nx == 4'd9) out_q <= 1'b1;
      else if (cmp_fire && mode_q == 4'd8)  out_q <= 1'b1;
      else if (cmp_fire && mode_q == 4'd9)  out_q <= 1'b0;
    end
  end

  assign out_en_o = is_pwm(mode_q) || (is_cmp(mode_q) && !mode_q[1]);
  assign out_o    = out_en_o && (is_pwm(mode_q) ? pwm_lvl : out_q);
  assign irq_o    = flag_q;
  assign trig_o   = trig_q;
  assign ccpr_o   = ccpr_q;
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] mode_q,
  input logic       clr_wr,
  input logic       period_i,
  input logic       out_o,
  input logic       out_en_o,
  input logic       irq_o,
  input logic       trig_o
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[3:2] == 2'b00 && $past(mode_q[3:2]) == 2'b00) |-> (!out_en_o && !out_o && !trig_o));

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);

  assert_set_mode_no_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'd8 && $past(mode_q) == 4'd8) |-> !$fell(out_o));

  assert_trig_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  assert_trig_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(mode_q) == 4'd11);

  assert_pwm_rise_at_period_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_o) && mode_q >= 4'd12 && $past(mode_q) >= 4'd12) |-> $past(period_i));
endmodule

bind ccp_channel ccp_channel_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_q   (mode_q),
  .clr_wr   (wr_en_i && wr_addr_i == 2'd3 && !wr_data_i[0]),
  .period_i (period_i),
  .out_o    (out_o),
  .out_en_o (out_en_o),
  .irq_o    (irq_o),
  .trig_o   (trig_o)
);

// File: tb/ccp_channel_test.sv
module ccp_channel_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int L = 16;  // period timer 0..3, sub-count 0..3

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] timer = '0;
  logic [7:0]  pwm_tmr = '0;
  logic [1:0]  pwm_sub = '0;
  logic        period = 1'b0;
  logic        pin = 1'b0;
  logic        out_o, out_en_o, irq_o, trig_o;
  logic [15:0] ccpr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ccp_channel uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .timer_i(timer), .pwm_tmr_i(pwm_tmr), .pwm_sub_i(pwm_sub),
    .period_i(period), .pin_i(pin), .out_o(out_o), .out_en_o(out_en_o),
    .irq_o(irq_o), .trig_o(trig_o), .ccpr_o(ccpr_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v);
    timer = v; pin = 1'b1;
    tick(); tick();
    pin = 1'b0;
    tick(); tick();
  endtask

  // one full period of the period timer, optional write at count wc
  task automatic pwm_period(input int wc, input logic [1:0] wa, input logic [7:0] wd,
                            output int highs);
    highs = 0;
    for (int c = 0; c < L; c++) begin
      pwm_tmr = 8'(c >> 2); pwm_sub = 2'(c & 3); period = (c == L - 1);
      if (c == wc) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
      highs += int'(out_o);
      tick();
      wr_en = 1'b0;
    end
    period = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_v;
    int h;
    #12;
    // R1 reset state
    chk("R1 out", out_o, 0); chk("R1 out_en", out_en_o, 0);
    chk("R1 irq", irq_o, 0); chk("R1 trig", trig_o, 0); chk("R1 ccpr", ccpr_o, 0);
    rst_ni = 1'b1;
    tick();

    // R2 idle modes: no capture, no compare effect
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, 8'(m)); wr(2'd1, 8'h5A); wr(2'd2, 8'hA5); wr(2'd3, 8'h00);
      pulse(16'hA55A); pulse(16'h1234);
      timer = 16'hA55A; tick();
      chk("R2 irq", irq_o, 0); chk("R2 ccpr", ccpr_o, 16'hA55A);
      chk("R2 out_en", out_en_o, 0); chk("R2 out", out_o, 0); chk("R2 trig", trig_o, 0);
    end

    // R3/R4 capture sweep over all edge modes
    for (int m = 4; m < 8; m++) begin
      wr(2'd0, 8'(m)); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
      exp_v = 16'h0;
      for (int k = 0; k < 40; k++) begin
        logic q;
        logic [15:0] v;
        wr(2'd3, 8'h00);
        v = 16'(m * 256 + k * 7 + 1);
        pulse(v);
        q = (m < 6) || (m == 6 && k % 4 == 3) || (m == 7 && k % 16 == 15);
        if (q) exp_v = v;
        chk(m < 6 ? "R3 capture value" : "R4 capture value", ccpr_o, exp_v);
        chk(m < 6 ? "R3 capture flag" : "R4 capture flag", irq_o, q);
      end
    end

    // R3 capture latency: second edge after pin change
    wr(2'd0, 8'd5); wr(2'd3, 8'h00);
    timer = 16'hBEEF; pin = 1'b1; tick();
    chk("R3 no capture after one edge", irq_o, 0);
    tick();
    chk("R3 capture after two edges", ccpr_o, 16'hBEEF);
    pin = 1'b0; tick(); tick();

    // R5 mode change clears partial prescale count
    wr(2'd0, 8'd6);
    for (int k = 0; k < 3; k++) pulse(16'h0300 + 16'(k));
    wr(2'd0, 8'd7); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    for (int k = 0; k < 15; k++) pulse(16'h0400 + 16'(k));
    chk("R5 no early capture flag", irq_o, 0);
    chk("R5 no early capture value", ccpr_o, 16'h0000);
    pulse(16'h0777);
    chk("R5 capture on 16th edge", ccpr_o, 16'h0777);

    // R7/R8 compare sweep
    for (int m = 8; m < 12; m++) begin
      logic [15:0] cvs [3];
      cvs[0] = 16'h0010; cvs[1] = 16'h8000; cvs[2] = 16'hFFFE;
      for (int i = 0; i < 3; i++) begin
        logic eo, ef;
        wr(2'd0, 8'd0);
        timer = cvs[i] - 16'd3;
        wr(2'd1, cvs[i][7:0]); wr(2'd2, cvs[i][15:8]); wr(2'd3, 8'h00);
        wr(2'd0, 8'(m));
        eo = (m == 9); ef = 1'b0;
        chk(m < 10 ? "R7 out_en" : "R8 out_en", out_en_o, (m < 10));
        chk(m < 10 ? "R7 entry level" : "R8 entry level", out_o, eo);
        for (int d = -3; d <= 2; d++) begin
          timer = cvs[i] + 16'(d);
          tick();
          if (d == 0) begin
            ef = 1'b1;
            if (m == 8) eo = 1'b1;
            if (m == 9) eo = 1'b0;
          end
          chk(m < 10 ? "R7 out" : "R8 out", out_o, (m < 10) ? eo : 1'b0);
          chk(m < 10 ? "R7 flag" : "R8 flag", irq_o, ef);
          chk("R8 trig", trig_o, (m == 11 && d == 0));
        end
      end
    end

    // R9 single event per equality, R6 clear rules
    wr(2'd0, 8'd10); wr(2'd1, 8'h40); wr(2'd2, 8'h00);
    timer = 16'h003F; wr(2'd3, 8'h00);
    timer = 16'h0040; tick();
    chk("R6 set by compare", irq_o, 1);
    wr(2'd3, 8'h01);
    chk("R6 write one no effect on set flag", irq_o, 1);
    wr(2'd3, 8'h00);
    chk("R6 cleared by zero", irq_o, 0);
    repeat (4) tick();
    chk("R9 no repeat while equal", irq_o, 0);
    wr(2'd3, 8'h01);
    chk("R6 write one does not set", irq_o, 0);
    timer = 16'h003F; tick();
    timer = 16'h0040;
    wr(2'd3, 8'h00);
    chk("R6 event wins over clear", irq_o, 1);

    // R10 duty sweep, mode 12
    for (int d = 0; d < 19; d++) begin
      wr(2'd2, 8'(d >> 2));
      wr(2'd0, 8'(((d & 3) << 4) | 12));
      pwm_period(-1, 2'd0, 8'd0, h);
      pwm_period(-1, 2'd0, 8'd0, h);
      chk("R10 high cycles", h, (d < L) ? d : L);
      chk("R10 out_en", out_en_o, 1);
    end

    // R10 other PWM encodings
    for (int m = 13; m < 16; m++) begin
      wr(2'd2, 8'd2);
      wr(2'd0, 8'((1 << 4) | m));
      pwm_period(-1, 2'd0, 8'd0, h);
      pwm_period(-1, 2'd0, 8'd0, h);
      chk("R10 duty 9 in alt mode", h, 9);
    end

    // R11 double buffering
    wr(2'd2, 8'd1);
    wr(2'd0, 8'((2 << 4) | 12));
    pwm_period(-1, 2'd0, 8'd0, h);
    pwm_period(2, 2'd2, 8'd4, h);
    chk("R11 old duty kept this period", h, 6);
    pwm_period(-1, 2'd0, 8'd0, h);
    chk("R11 new duty next period", h, 16);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule